// File: doc/BRIEF.md
# Follower Beacon-Loss Watchdog

This block keeps track of whether a follower node on a shared-medium segment is still hearing its coordinator's beacons. It decides from that whether the node runs in the coordinated, collision-free mode (PLCA) or falls back to plain CSMA/CD.

Between beacons the node keeps advancing a transmit opportunity counter on each opportunity-advance strobe, and the counter stops at its ceiling. Once the counter has sat at its ceiling for a programmable number of clock cycles with no beacon, the active status drops and the fallback indication rises. The next beacon brings the status back. Each beacon also closes a bus cycle, and the opportunity count reached in that cycle is latched as the maximum ID.

All ports are plain level or strobe signals with no handshake. The strobes are sampled on every clock edge and cannot be refused, so the block applies no back-pressure. The generation of the opportunity strobes and the host register access are left to neighbouring logic.

Top module: `plca_beacon_watchdog`

## Requirements
- R1: After reset, `plca_active_o` is 0, `csma_fallback_o` is 1, `status_chg_o` is 0 and `max_id_o` is 0.
- R2: A beacon strobe sets `plca_active_o` from the next clock edge on. `csma_fallback_o` is always the inverse of `plca_active_o`.
- R3: Each `to_adv_i` strobe without a beacon in the same cycle raises the opportunity count by one. The count stops at CNT_MAX (default 255) and never wraps.
- R4: A beacon clears the opportunity count to 0. An advance strobe in the same cycle as a beacon is ignored.
- R5: On each beacon, `max_id_o` takes the opportunity count as it stood just before that beacon. It then holds that value until the next beacon.
- R6: While active, once the count has reached CNT_MAX, `plca_active_o` falls exactly TIMEOUT_CYC clock edges after the edge on which the count became CNT_MAX, provided no beacon arrives in that time.
- R7: A beacon while the timeout runs cancels it. The status stays 1, and a later loss again needs a full TIMEOUT_CYC cycles at the ceiling.
- R8: `status_chg_o` is high for exactly one cycle, in the same cycle that `plca_active_o` shows a new value, and is low otherwise.
- R9: While inactive, the status stays 0 whatever `to_adv_i` does, until a beacon arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beacon_i | input | 1 | One-cycle strobe: a beacon was received |
| to_adv_i | input | 1 | One-cycle strobe: advance to the next transmit opportunity |
| plca_active_o | output | 1 | Coordinated mode active |
| status_chg_o | output | 1 | One-cycle pulse on any change of `plca_active_o` |
| csma_fallback_o | output | 1 | Node operates in CSMA/CD |
| max_id_o | output | CNT_W (8) | Opportunity count latched at the last beacon |

## Verification
The bench sweeps the number of advances between two beacons from 0 up past the ceiling. A counter that wraps, or one that counts an advance arriving together with a beacon, would then report a wrong maximum ID. It counts the clock edges from saturation to the drop of the status, so a timer off by one cycle, or one started at the wrong edge, is seen. It also sends a beacon one cycle before expiry and then lets a second loss run the full interval, which catches a timer that is not cleared. The change pulse is checked on both the rising and the falling status.

// File: rtl/plca_wd_pkg.sv
package plca_wd_pkg;
  typedef enum logic {
    MODE_CSMA = 1'b0,
    MODE_PLCA = 1'b1
  } plca_mode_e;
endpackage

// File: rtl/wd_opp_counter.sv
module wd_opp_counter #(
  parameter int CNT_MAX = 255,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_MAX);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (clear_i)                cnt_q <= '0;
    else if (adv_i && cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign sat_o = (cnt_q == TOP);
endmodule

// File: rtl/wd_loss_timer.sv
module wd_loss_timer #(
  parameter int TIMEOUT_CYC = 1625000,
  parameter int TMR_W       = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic             expire_o
);
  localparam logic [TMR_W-1:0] LAST = TMR_W'(TIMEOUT_CYC - 1);

  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      tmr_q <= '0;
    else if (!run_i || tmr_q == LAST) tmr_q <= '0;
    else                             tmr_q <= tmr_q + 1'b1;
  end

  assign tmr_o    = tmr_q;
  assign expire_o = run_i && (tmr_q == LAST);
endmodule

// File: rtl/wd_maxid_latch.sv
module wd_maxid_latch #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] value_i,
  output logic [CNT_W-1:0] max_id_o
);
  logic [CNT_W-1:0] id_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      id_q <= '0;
    else if (load_i) id_q <= value_i;
  end

  assign max_id_o = id_q;
endmodule

// File: rtl/plca_beacon_watchdog.sv
module plca_beacon_watchdog
  import plca_wd_pkg::*;
#(
  parameter int CNT_MAX     = 255,
  parameter int TIMEOUT_CYC = 1625000,
  localparam int CNT_W      = $clog2(CNT_MAX + 1),
  localparam int TMR_W      = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beacon_i,
  input  logic             to_adv_i,
  output logic             plca_active_o,
  output logic             status_chg_o,
  output logic             csma_fallback_o,
  output logic [CNT_W-1:0] max_id_o
);
  plca_mode_e       mode_q, mode_d;
  logic             chg_q;
  logic [CNT_W-1:0] opp_cnt;
  logic             opp_sat;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_run, tmr_expire;

  wd_opp_counter #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_opp (
    .clk(clk), .rst_n(rst_n), .clear_i(beacon_i), .adv_i(to_adv_i),
    .cnt_o(opp_cnt), .sat_o(opp_sat)
  );

  assign tmr_run = opp_sat && (mode_q == MODE_PLCA) && !beacon_i;

  wd_loss_timer #(.TIMEOUT_CYC(TIMEOUT_CYC), .TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run_i(tmr_run),
    .tmr_o(tmr_val), .expire_o(tmr_expire)
  );

  wd_maxid_latch #(.CNT_W(CNT_W)) u_maxid (
    .clk(clk), .rst_n(rst_n), .load_i(beacon_i), .value_i(opp_cnt),
    .max_id_o(max_id_o)
  );

  always_comb begin
    mode_d = mode_q;
    if (beacon_i)        mode_d = MODE_PLCA;
    else if (tmr_expire) mode_d = MODE_CSMA;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_CSMA;
      chg_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      chg_q  <= (mode_d != mode_q);
    end
  end

  assign plca_active_o   = (mode_q == MODE_PLCA);
  assign csma_fallback_o = (mode_q == MODE_CSMA);
  assign status_chg_o    = chg_q;
endmodule

// File: rtl/plca_beacon_watchdog_chk.sv
module plca_beacon_watchdog_chk #(
  parameter int CNT_MAX = 255,
  parameter int CNT_W   = 8,
  parameter int TMR_W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             beacon_i,
  input logic             to_adv_i,
  input logic             plca_active_o,
  input logic             status_chg_o,
  input logic             csma_fallback_o,
  input logic [CNT_W-1:0] max_id_o,
  input logic [CNT_W-1:0] opp_cnt,
  input logic [TMR_W-1:0] tmr_val
);
  AST_FALLBACK_INV: assert property (@(posedge clk) disable iff (!rst_n)
    csma_fallback_o == !plca_active_o); // R2
  AST_BEACON_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    beacon_i |=> plca_active_o); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    opp_cnt <= CNT_W'(CNT_MAX)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!beacon_i && to_adv_i && opp_cnt != CNT_W'(CNT_MAX)) |=> opp_cnt == $past(opp_cnt) + 1'b1); // R3
  AST_BEACON_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    beacon_i |=> opp_cnt == '0); // R4
  AST_MAXID_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    beacon_i |=> max_id_o == $past(opp_cnt)); // R5
  AST_MAXID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !beacon_i |=> $stable(max_id_o)); // R5
  AST_DROP_AT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(plca_active_o) |-> $past(opp_cnt) == CNT_W'(CNT_MAX)); // R6
  AST_TMR_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    beacon_i |=> tmr_val == '0); // R7
  AST_CHG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    status_chg_o == (plca_active_o != $past(plca_active_o))); // R8
  AST_INACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!plca_active_o && !beacon_i) |=> !plca_active_o); // R9
endmodule

bind plca_beacon_watchdog plca_beacon_watchdog_chk #(
  .CNT_MAX(CNT_MAX), .CNT_W(CNT_W), .TMR_W(TMR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .beacon_i(beacon_i), .to_adv_i(to_adv_i),
  .plca_active_o(plca_active_o), .status_chg_o(status_chg_o),
  .csma_fallback_o(csma_fallback_o), .max_id_o(max_id_o),
  .opp_cnt(opp_cnt), .tmr_val(tmr_val)
);

// File: tb/plca_beacon_watchdog_tb.sv
module plca_beacon_watchdog_tb;
  localparam int CMAX = 255;
  localparam int TO   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic beacon_i = 1'b0;
  logic to_adv_i = 1'b0;
  logic plca_active_o, status_chg_o, csma_fallback_o;
  logic [7:0] max_id_o;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  plca_beacon_watchdog #(.CNT_MAX(CMAX), .TIMEOUT_CYC(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .beacon_i(beacon_i), .to_adv_i(to_adv_i),
    .plca_active_o(plca_active_o), .status_chg_o(status_chg_o),
    .csma_fallback_o(csma_fallback_o), .max_id_o(max_id_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int act_exp, input int chg_exp);
    chk(req, int'(plca_active_o), act_exp);
    chk(req, int'(csma_fallback_o), 1 - act_exp);
    chk(req, int'(status_chg_o), chg_exp);
  endtask

  // beacon held for one edge; returns at the following negedge
  task automatic beacon(input logic with_adv);
    beacon_i = 1'b1;
    to_adv_i = with_adv;
    @(posedge clk);
    @(negedge clk);
    beacon_i = 1'b0;
    to_adv_i = 1'b0;
  endtask

  task automatic adv(input int n);
    if (n > 0) begin
      to_adv_i = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      to_adv_i = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk_state("R1", 0, 0);
    chk("R1", int'(max_id_o), 0);

    // R9 advances while inactive do not raise the status
    adv(300);
    idle(TO + 5);
    chk_state("R9", 0, 0);

    // R2 / R8 first beacon; R5 latches saturated count
    beacon(1'b0);
    chk_state("R2", 1, 1);
    chk("R5", int'(max_id_o), CMAX);
    idle(1);
    chk_state("R8", 1, 0);

    // R3 / R5 sweep of advance counts below the ceiling
    for (int n = 0; n <= 40; n++) begin
      adv(n);
      beacon(1'b0);
      chk("R5", int'(max_id_o), n);
    end
    for (int n = 250; n <= 254; n++) begin
      adv(n);
      beacon(1'b0);
      chk("R3", int'(max_id_o), n);
    end

    // R4 advance coincident with beacon is ignored
    adv(3);
    beacon(1'b1);
    chk("R4", int'(max_id_o), 3);
    beacon(1'b1);
    chk("R4", int'(max_id_o), 0);
    idle(2);
    chk("R5", int'(max_id_o), 0);

    // R6 exact drop timing after saturation
    adv(CMAX);
    idle(TO - 1);
    chk_state("R6", 1, 0);
    idle(1);
    chk_state("R6", 0, 1);
    idle(1);
    chk_state("R8", 0, 0);
    adv(10);
    chk_state("R9", 0, 0);

    // R7 beacon one cycle before expiry cancels the timeout
    beacon(1'b0);
    chk_state("R8", 1, 1);
    adv(CMAX);
    idle(TO - 2);
    beacon(1'b0);
    chk_state("R7", 1, 0);
    chk("R7", int'(max_id_o), CMAX);
    adv(CMAX);
    idle(TO - 1);
    chk_state("R7", 1, 0);
    idle(1);
    chk_state("R7", 0, 1);

    // R3 counter never wraps when over-driven; status lost meanwhile
    beacon(1'b0);
    adv(CMAX + TO + 30);
    chk_state("R6", 0, 0);
    beacon(1'b0);
    chk("R3", int'(max_id_o), CMAX);
    chk_state("R8", 1, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule